// File: doc/BRIEF.md
# Input Scan Sequencer

This block steps an analog-to-digital converter through a group of positive inputs, one after another, without help from software. A mask with one bit per input picks which inputs take part. A trigger starts a scan at the lowest input that is enabled. Each time the converter reports that a conversion is finished, the sequencer picks the next enabled input above the one just converted and asks for a new conversion. When the highest enabled input has been converted, the scan stops.

There are two trigger inputs. The plain start trigger, from software or from an event, has an effect only when no scan is running. The flush trigger aborts any scan in progress and starts a new one from the lowest enabled input. When the mask is all zeros, scanning is switched off: triggers do nothing and the selected input stays where it was. Two status outputs tell whether a scan is in progress and which input was converted most recently.

The converter's timing and the analog multiplexer are outside this block. The block only drives the input index and a conversion-start pulse, and reacts to the converter's done pulse.

Top module: `scan_sequencer`

## Requirements
- R1: A start or flush trigger with a nonzero mask sets `sel_idx` to the lowest set bit of `en_mask` and sets `seq_busy` to 1. `conv_start` is 1 in the cycle after the trigger's clock edge.
- R2: When `conv_done` arrives while busy and a higher mask bit is set, `sel_idx` moves to the lowest set bit above the current index, and `conv_start` pulses in the next cycle.
- R3: Every `conv_done` accepted while busy, without a flush in the same cycle, copies the index just converted into `last_idx`.
- R4: When `conv_done` arrives for the highest enabled input, `seq_busy` goes to 0, no `conv_start` is issued, and `sel_idx` keeps that highest index.
- R5: With an all-zero mask, start and flush triggers are ignored while idle: `seq_busy` and `conv_start` stay 0 and `sel_idx` is unchanged.
- R6: A start trigger that arrives while busy is ignored: `sel_idx` is unchanged, no `conv_start` is issued, and `seq_busy` stays 1.
- R7: A flush trigger takes priority over `conv_done` and `start_trig`. It restarts the scan from the lowest enabled input and leaves `last_idx` unchanged. If the mask is zero at that moment, it ends the scan (`seq_busy` goes to 0) and `sel_idx` stays where it was.
- R8: After the synchronous reset, `sel_idx`, `last_idx`, `seq_busy` and `conv_start` are all 0.
- R9: A `conv_done` pulse while idle has no effect on any output.
- R10: `conv_start` is a one-cycle pulse. It is asserted only while `seq_busy` is 1, and only for an index whose mask bit was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_mask | input | NUM_INPUTS | One enable bit per positive input; bit i enables input i |
| start_trig | input | 1 | Start pulse from software or an event |
| flush_trig | input | 1 | Abort the current scan and restart it |
| conv_done | input | 1 | Converter finished the current conversion |
| sel_idx | output | IDX_W | Index of the selected input |
| conv_start | output | 1 | One-cycle request to start a conversion |
| seq_busy | output | 1 | A scan is in progress |
| last_idx | output | IDX_W | Index of the most recently completed conversion |

## Verification
Each single-bit mask is run, which covers the boundary where the first input is also the last. A design that looked one index too far, or that failed to stop, would run past the end or skip input 0 or input 31. Sparse masks, the full mask and pseudo-random masks check that gaps are skipped in ascending order; a priority encoder that picked the highest bit, or included the current bit, would repeat or reverse the order. Separate checks cover a start trigger while busy, a flush that lands in the same cycle as a done pulse, a flush when the mask has become zero, and done pulses while idle. A design that let a stray event reach its state would move `sel_idx` or `last_idx`.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

  // Decision taken by the controller in one cycle
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,
    ACT_LAUNCH  = 3'd1,
    ACT_ADVANCE = 3'd2,
    ACT_FINISH  = 3'd3,
    ACT_ABORT   = 3'd4
  } seq_act_e;

endpackage

// File: rtl/scanseq_lowest_pick.sv
module scanseq_lowest_pick #(
  parameter int WIDTH = 32,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins; scanning downward lets the last hit be the lowest
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign found = |vec;

endmodule

// File: rtl/scanseq_next_finder.sv
module scanseq_next_finder #(
  parameter int NUM_INPUTS = 32,
  parameter int IDX_W      = $clog2(NUM_INPUTS)
) (
  input  logic [NUM_INPUTS-1:0] mask,
  input  logic [IDX_W-1:0]      cur,
  output logic                  first_found,
  output logic [IDX_W-1:0]      first_idx,
  output logic                  next_found,
  output logic [IDX_W-1:0]      next_idx
);

  logic [NUM_INPUTS-1:0] above;
  logic [NUM_INPUTS-1:0] upper_mask;

  // Qualifier: bit i is a candidate only when strictly above the current index
  for (genvar gi = 0; gi < NUM_INPUTS; gi++) begin : g_above
    assign above[gi] = (IDX_W'(gi) > cur);
  end

  assign upper_mask = mask & above;

  scanseq_lowest_pick #(.WIDTH(NUM_INPUTS), .IDX_W(IDX_W)) u_first (
    .vec   (mask),
    .found (first_found),
    .idx   (first_idx)
  );

  scanseq_lowest_pick #(.WIDTH(NUM_INPUTS), .IDX_W(IDX_W)) u_next (
    .vec   (upper_mask),
    .found (next_found),
    .idx   (next_idx)
  );

endmodule

// File: rtl/scanseq_ctrl.sv
module scanseq_ctrl
  import scanseq_pkg::*;
#(
  parameter int NUM_INPUTS = 32,
  parameter int IDX_W      = $clog2(NUM_INPUTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_INPUTS-1:0] en_mask,
  input  logic                  start_trig,
  input  logic                  flush_trig,
  input  logic                  conv_done,
  input  logic                  first_found,
  input  logic [IDX_W-1:0]      first_idx,
  input  logic                  next_found,
  input  logic [IDX_W-1:0]      next_idx,
  output logic [IDX_W-1:0]      sel_idx,
  output logic                  conv_start,
  output logic                  seq_busy,
  output logic [IDX_W-1:0]      last_idx
);

  seq_act_e act;

  // Flush first, then completion, then a fresh start from idle
  always_comb begin
    act = ACT_HOLD;
    if (flush_trig) begin
      act = first_found ? ACT_LAUNCH : ACT_ABORT;
    end else if (seq_busy && conv_done) begin
      act = next_found ? ACT_ADVANCE : ACT_FINISH;
    end else if (!seq_busy && start_trig && first_found) begin
      act = ACT_LAUNCH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx    <= '0;
      last_idx   <= '0;
      seq_busy   <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (act)
        ACT_LAUNCH: begin
          sel_idx    <= first_idx;
          seq_busy   <= 1'b1;
          conv_start <= 1'b1;
        end
        ACT_ADVANCE: begin
          last_idx   <= sel_idx;
          sel_idx    <= next_idx;
          conv_start <= 1'b1;
        end
        ACT_FINISH: begin
          last_idx <= sel_idx;
          seq_busy <= 1'b0;
        end
        ACT_ABORT: begin
          seq_busy <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // Mask seen at the edge that launched the current conversion
  logic [NUM_INPUTS-1:0] mask_prev;
  always_ff @(posedge clk) begin
    if (rst) mask_prev <= '0;
    else     mask_prev <= en_mask;
  end

  AST_START_ENABLED_BIT: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (seq_busy && mask_prev[sel_idx])); // R10

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> (!conv_start || $past(seq_busy && (conv_done || flush_trig)))); // R10

  AST_ADVANCE_UPWARD: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && conv_done && !flush_trig) |=> (!seq_busy || (sel_idx > $past(sel_idx)))); // R2

  AST_LAST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && conv_done && !flush_trig) |=> (last_idx == $past(sel_idx))); // R3

  AST_ZERO_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && (en_mask == '0)) |=> (!seq_busy && !conv_start && $stable(sel_idx))); // R5

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && start_trig && !flush_trig && !conv_done) |=> (seq_busy && !conv_start && $stable(sel_idx))); // R6

  AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (rst)
    (flush_trig && (en_mask != '0)) |=> (seq_busy && conv_start && $stable(last_idx))); // R7

  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && conv_done && !start_trig && !flush_trig) |=> (!seq_busy && $stable(sel_idx) && $stable(last_idx))); // R9

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter  int NUM_INPUTS = 32,
  localparam int IDX_W      = $clog2(NUM_INPUTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_INPUTS-1:0] en_mask,
  input  logic                  start_trig,
  input  logic                  flush_trig,
  input  logic                  conv_done,
  output logic [IDX_W-1:0]      sel_idx,
  output logic                  conv_start,
  output logic                  seq_busy,
  output logic [IDX_W-1:0]      last_idx
);

  logic             first_found;
  logic [IDX_W-1:0] first_idx;
  logic             next_found;
  logic [IDX_W-1:0] next_idx;

  scanseq_next_finder #(.NUM_INPUTS(NUM_INPUTS), .IDX_W(IDX_W)) u_finder (
    .mask        (en_mask),
    .cur         (sel_idx),
    .first_found (first_found),
    .first_idx   (first_idx),
    .next_found  (next_found),
    .next_idx    (next_idx)
  );

  scanseq_ctrl #(.NUM_INPUTS(NUM_INPUTS), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en_mask     (en_mask),
    .start_trig  (start_trig),
    .flush_trig  (flush_trig),
    .conv_done   (conv_done),
    .first_found (first_found),
    .first_idx   (first_idx),
    .next_found  (next_found),
    .next_idx    (next_idx),
    .sel_idx     (sel_idx),
    .conv_start  (conv_start),
    .seq_busy    (seq_busy),
    .last_idx    (last_idx)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!seq_busy && !conv_start && (sel_idx == '0) && (last_idx == '0))); // R8

  AST_FINISH_STOPS: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && conv_done && !flush_trig && !next_found) |=> (!seq_busy && !conv_start && $stable(sel_idx))); // R4

endmodule

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb;

  localparam int N     = 32;
  localparam int W     = 5;
  localparam int DELAY = 3;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] en_mask;
  logic         start_trig;
  logic         flush_trig;
  logic         conv_done;
  logic [W-1:0] sel_idx;
  logic         conv_start;
  logic         seq_busy;
  logic [W-1:0] last_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scan_sequencer #(.NUM_INPUTS(N)) u_dut (
    .clk(clk), .rst(rst), .en_mask(en_mask), .start_trig(start_trig),
    .flush_trig(flush_trig), .conv_done(conv_done), .sel_idx(sel_idx),
    .conv_start(conv_start), .seq_busy(seq_busy), .last_idx(last_idx)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest_of(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int next_above(input logic [N-1:0] m, input int cur);
    for (int i = cur + 1; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Full scan of one mask with a converter model of fixed delay
  task automatic run_seq(input logic [N-1:0] m);
    int  exp;
    int  nxt;
    bit  running;
    en_mask = m;
    start_trig = 1'b1;
    @(negedge clk);
    start_trig = 1'b0;
    exp = lowest_of(m);
    check("R1", "first sel_idx", int'(sel_idx), exp);
    check("R1", "conv_start", int'(conv_start), 1);
    check("R1", "seq_busy", int'(seq_busy), 1);
    running = 1;
    while (running) begin
      @(negedge clk);
      check("R10", "conv_start pulse width", int'(conv_start), 0);
      repeat (DELAY - 2) @(negedge clk);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      check("R3", "last_idx", int'(last_idx), exp);
      nxt = next_above(m, exp);
      if (nxt >= 0) begin
        check("R2", "next sel_idx", int'(sel_idx), nxt);
        check("R2", "conv_start", int'(conv_start), 1);
        exp = nxt;
      end else begin
        check("R4", "seq_busy at end", int'(seq_busy), 0);
        check("R4", "conv_start at end", int'(conv_start), 0);
        check("R4", "sel_idx held", int'(sel_idx), exp);
        running = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [N-1:0] lfsr;
    logic [W-1:0] s_sel;
    logic [W-1:0] s_last;
    rst = 1'b1; en_mask = '0; start_trig = 1'b0; flush_trig = 1'b0; conv_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "sel_idx", int'(sel_idx), 0);
    check("R8", "last_idx", int'(last_idx), 0);
    check("R8", "seq_busy", int'(seq_busy), 0);
    check("R8", "conv_start", int'(conv_start), 0);
    rst = 1'b0;
    @(negedge clk);

    // Single-bit masks: first input is also the last
    for (int b = 0; b < N; b++) run_seq(N'(1) << b);
    // Sparse, full and structured masks
    run_seq(32'h8000_0001);
    run_seq(32'hFFFF_FFFF);
    run_seq(32'h0000_0006);
    run_seq(32'h4210_8421);
    lfsr = 32'h1234_5678;
    for (int k = 0; k < 12; k++) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      if (lfsr == '0) lfsr = 32'h1;
      run_seq(lfsr);
    end

    // R9: done while idle
    s_sel = sel_idx; s_last = last_idx;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check("R9", "sel_idx", int'(sel_idx), int'(s_sel));
    check("R9", "last_idx", int'(last_idx), int'(s_last));
    check("R9", "seq_busy", int'(seq_busy), 0);

    // R5: zero mask disables both triggers
    en_mask = '0;
    s_sel = sel_idx;
    start_trig = 1'b1;
    @(negedge clk);
    start_trig = 1'b0;
    check("R5", "busy after start", int'(seq_busy), 0);
    check("R5", "conv_start after start", int'(conv_start), 0);
    check("R5", "sel_idx after start", int'(sel_idx), int'(s_sel));
    flush_trig = 1'b1;
    @(negedge clk);
    flush_trig = 1'b0;
    check("R5", "busy after flush", int'(seq_busy), 0);
    check("R5", "sel_idx after flush", int'(sel_idx), int'(s_sel));

    // R6: start while busy is ignored
    en_mask = 32'h0000_0122;
    start_trig = 1'b1;
    @(negedge clk);
    check("R1", "sel_idx", int'(sel_idx), 1);
    @(negedge clk);
    start_trig = 1'b0;
    check("R6", "sel_idx", int'(sel_idx), 1);
    check("R6", "conv_start", int'(conv_start), 0);
    check("R6", "seq_busy", int'(seq_busy), 1);
    conv_done = 1'b1;
    @(negedge clk);
    check("R2", "sel_idx", int'(sel_idx), 5);
    @(negedge clk);
    conv_done = 1'b0;
    check("R2", "sel_idx", int'(sel_idx), 8);
    check("R3", "last_idx", int'(last_idx), 5);

    // R7: flush together with done restarts and keeps last_idx
    flush_trig = 1'b1; conv_done = 1'b1;
    @(negedge clk);
    flush_trig = 1'b0; conv_done = 1'b0;
    check("R7", "sel_idx", int'(sel_idx), 1);
    check("R7", "conv_start", int'(conv_start), 1);
    check("R7", "seq_busy", int'(seq_busy), 1);
    check("R7", "last_idx", int'(last_idx), 5);

    // R7: flush with mask now zero ends the scan
    en_mask = '0;
    flush_trig = 1'b1;
    @(negedge clk);
    flush_trig = 1'b0;
    check("R7", "busy after zero flush", int'(seq_busy), 0);
    check("R7", "conv_start after zero flush", int'(conv_start), 0);
    check("R7", "sel_idx after zero flush", int'(sel_idx), 1);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule